// File: doc/BRIEF.md
# Return-from-Interrupt Machine State Restore

This block is the combinational core that rebuilds the processor's machine-state word and the resume address when a return-from-interrupt operation runs. It takes three 64-bit values: the machine state in force now, the machine state saved when the interrupt was taken, and the address saved at that time. From these it produces the new machine state and the address to fetch next. Each output carries a valid flag, and the flags are raised only while the operation input marks a return-from-interrupt.

Bits are numbered big-endian: bit 0 is the most significant bit of a 64-bit word and bit 63 is the least significant. Most bits of the new state come straight from the saved word. A few follow conditional rules. The machine-check enable is restored only while the hypervisor bit is set. The three-bit field at bits 29..31 has one protected combination. The saved problem-state bit forces three enable bits on. The resume address is the saved address with its low two bits cleared.

Top module: `rfi_restore`

## Requirements
- R1: New-state bits 0..2, 4..28, 32, 37..41, 49..50, 52..57 and 60..63 equal the same bits of the saved state.
- R2: New-state bit 51 equals saved bit 51 when current-state bit 3 is 1. Otherwise it equals current bit 51.
- R3: New-state bits 29..31 equal saved bits 29..31, with one exception. When current bits 29..31 read 0b010 (bit 30 set) and saved bits 29..31 read 0b000, they keep the current value.
- R4: New-state bits 48, 58 and 59 each equal the saved value of that bit ORed with saved bit 49.
- R5: New-state bits 3, 33..36 and 42..47 keep their current-state values.
- R6: The next address equals the saved address with bits 62 and 63 (the two least significant bits) forced to 0, and all other bits unchanged.
- R7: When `op_is_rfi` is 1, `new_msr_vld` and `next_addr_vld` are both 1.
- R8: When `op_is_rfi` is 0, `new_msr_vld` and `next_addr_vld` are both 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_is_rfi | input | 1 | Current operation is a return-from-interrupt |
| cur_msr | input | 64 | Machine state in force now |
| saved_msr | input | 64 | Machine state saved at interrupt entry |
| saved_addr | input | 64 | Address saved at interrupt entry |
| new_msr | output | 64 | Rebuilt machine state |
| new_msr_vld | output | 1 | New machine state is valid |
| next_addr | output | 64 | Address to resume fetching from |
| next_addr_vld | output | 1 | Next address is valid |

## Verification
The bench builds the block with the default word width of 64 and an alignment of two low bits. These are the only settings for which the fixed bit positions above carry meaning. With these values, every rule class is reachable from the vector table:
- the hypervisor-gated restore, in both polarities;
- the protected 0b010/0b000 combination and its near misses;
- the problem-state override, with the three enable bits saved as 0;
- resume addresses with both low bits set.

A separate directed case holds the operation input low to check that both valid flags drop.

// File: rtl/rfi_pkg.sv
package rfi_pkg;

    localparam int XLEN        = 64;
    localparam int ALIGN_DFLT  = 2;

    // Big-endian bit numbers of the rule-carrying fields
    localparam int HV_BIT      = 3;
    localparam int TRI_FIRST   = 29;
    localparam int TRI_LAST    = 31;
    localparam int TRI_W       = TRI_LAST - TRI_FIRST + 1;
    localparam int EE_BIT      = 48;
    localparam int PR_BIT      = 49;
    localparam int ME_BIT      = 51;
    localparam int IR_BIT      = 58;
    localparam int DR_BIT      = 59;

    localparam logic [TRI_W-1:0] TRI_HOLD_CUR   = 3'b010;
    localparam logic [TRI_W-1:0] TRI_HOLD_SAVED = 3'b000;

    typedef enum logic [2:0] {
        BC_COPY,
        BC_KEEP,
        BC_ME,
        BC_TRI,
        BC_PROB
    } bit_cls_e;

    typedef struct packed {
        logic hv;
        logic prob;
        logic tri_hold;
    } rfi_ctl_t;

    // Little-endian vector index for a big-endian bit number
    function automatic int le_idx(input int k);
        return XLEN - 1 - k;
    endfunction

    function automatic logic in_rng(input int k, input int lo, input int hi);
        return (k >= lo) && (k <= hi);
    endfunction

    // Restore rule that applies to one big-endian bit
    function automatic bit_cls_e classify(input int k);
        if (k == ME_BIT)
            return BC_ME;
        if (in_rng(k, TRI_FIRST, TRI_LAST))
            return BC_TRI;
        if ((k == EE_BIT) || (k == IR_BIT) || (k == DR_BIT))
            return BC_PROB;
        if (in_rng(k, 0, 2) || in_rng(k, 4, 28) || (k == 32) ||
            in_rng(k, 37, 41) || in_rng(k, 49, 50) ||
            in_rng(k, 52, 57) || in_rng(k, 60, 63))
            return BC_COPY;
        return BC_KEEP;
    endfunction

endpackage

// File: rtl/rfi_ctl_decode.sv
module rfi_ctl_decode
    import rfi_pkg::*;
(
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] saved_msr,
    output rfi_ctl_t        ctl
);

    localparam int TRI_TOP = le_idx(TRI_FIRST);

    logic [TRI_W-1:0] tri_cur;
    logic [TRI_W-1:0] tri_sav;

    always_comb begin
        tri_cur      = cur_msr[TRI_TOP -: TRI_W];
        tri_sav      = saved_msr[TRI_TOP -: TRI_W];
        ctl.hv       = cur_msr[le_idx(HV_BIT)];
        ctl.prob     = saved_msr[le_idx(PR_BIT)];
        ctl.tri_hold = (tri_cur == TRI_HOLD_CUR) && (tri_sav == TRI_HOLD_SAVED);
    end

endmodule

// File: rtl/rfi_msr_merge.sv
module rfi_msr_merge
    import rfi_pkg::*;
(
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] saved_msr,
    input  rfi_ctl_t        ctl,
    output logic [XLEN-1:0] new_msr
);

    for (genvar i = 0; i < XLEN; i++) begin : g_bit
        localparam bit_cls_e CLS = classify(XLEN - 1 - i);
        if (CLS == BC_COPY) begin : g_copy
            assign new_msr[i] = saved_msr[i];
        end else if (CLS == BC_ME) begin : g_me
            assign new_msr[i] = ctl.hv ? saved_msr[i] : cur_msr[i];
        end else if (CLS == BC_TRI) begin : g_tri
            assign new_msr[i] = ctl.tri_hold ? cur_msr[i] : saved_msr[i];
        end else if (CLS == BC_PROB) begin : g_prob
            assign new_msr[i] = saved_msr[i] | ctl.prob;
        end else begin : g_keep
            assign new_msr[i] = cur_msr[i];
        end
    end

    always_comb begin
        // R2
        me_hold_chk: assert (cur_msr[le_idx(HV_BIT)] ||
                             (new_msr[le_idx(ME_BIT)] == cur_msr[le_idx(ME_BIT)]))
            else $error("machine-check enable changed without hypervisor");
        // R4
        prob_force_chk: assert (!saved_msr[le_idx(PR_BIT)] ||
                                (new_msr[le_idx(EE_BIT)] && new_msr[le_idx(IR_BIT)] &&
                                 new_msr[le_idx(DR_BIT)]))
            else $error("problem state did not force enables");
        // R1
        pr_copy_chk: assert (new_msr[le_idx(PR_BIT)] == saved_msr[le_idx(PR_BIT)])
            else $error("problem-state bit not restored");
        // R5
        hv_keep_chk: assert (new_msr[le_idx(HV_BIT)] == cur_msr[le_idx(HV_BIT)])
            else $error("hypervisor bit altered");
    end

endmodule

// File: rtl/rfi_addr_align.sv
module rfi_addr_align
    import rfi_pkg::*;
#(
    parameter int ALIGN_BITS = ALIGN_DFLT
) (
    input  logic [XLEN-1:0] addr_in,
    output logic [XLEN-1:0] addr_out
);

    localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << ALIGN_BITS) - XLEN'(1);

    always_comb begin
        addr_out = addr_in & ~LOW_MASK;
    end

    always_comb begin
        // R6
        align_low_chk: assert ((addr_out & LOW_MASK) == '0)
            else $error("resume address not aligned");
        // R6
        align_high_chk: assert ((addr_out >> ALIGN_BITS) == (addr_in >> ALIGN_BITS))
            else $error("resume address upper bits altered");
    end

endmodule

// File: rtl/rfi_restore.sv
module rfi_restore
    import rfi_pkg::*;
#(
    parameter int ALIGN_BITS = ALIGN_DFLT
) (
    input  logic            op_is_rfi,
    input  logic [XLEN-1:0] cur_msr,
    input  logic [XLEN-1:0] saved_msr,
    input  logic [XLEN-1:0] saved_addr,
    output logic [XLEN-1:0] new_msr,
    output logic            new_msr_vld,
    output logic [XLEN-1:0] next_addr,
    output logic            next_addr_vld
);

    rfi_ctl_t ctl;

    rfi_ctl_decode u_dec (
        .cur_msr   (cur_msr),
        .saved_msr (saved_msr),
        .ctl       (ctl)
    );

    rfi_msr_merge u_merge (
        .cur_msr   (cur_msr),
        .saved_msr (saved_msr),
        .ctl       (ctl),
        .new_msr   (new_msr)
    );

    rfi_addr_align #(.ALIGN_BITS(ALIGN_BITS)) u_align (
        .addr_in  (saved_addr),
        .addr_out (next_addr)
    );

    always_comb begin
        new_msr_vld   = op_is_rfi;
        next_addr_vld = op_is_rfi;
    end

    always_comb begin
        // R7
        vld_pair_chk: assert (new_msr_vld == next_addr_vld)
            else $error("valid flags disagree");
        // R3
        tri_keep_chk: assert (!ctl.tri_hold ||
                              (new_msr[le_idx(TRI_FIRST) -: TRI_W] == TRI_HOLD_CUR))
            else $error("protected field overwritten");
    end

endmodule

// File: tb/tb_rfi_restore.sv
module tb_rfi_restore;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    logic        clk = 1'b0;
    logic        op_is_rfi;
    logic [63:0] cur_msr, saved_msr, saved_addr;
    logic [63:0] new_msr, next_addr;
    logic        new_msr_vld, next_addr_vld;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // {current state, saved state, saved address}
    localparam logic [191:0] VEC [NVEC] = '{
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_0000},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF},
        {64'h0000_0002_0000_0000, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1001},
        {64'h1000_0002_0000_1000, 64'h0000_0001_0000_0000, 64'h8000_0000_0000_0002},
        {64'h0000_0000_0000_0000, 64'h0000_0000_0000_4000, 64'h0000_0000_0000_0003},
        {64'h1000_0000_0000_0000, 64'hA5A5_5A5A_C3C3_3C3C, 64'hDEAD_BEEF_0000_0007},
        {64'h5A5A_A5A5_3C3C_C3C3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEF3},
        {64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF, 64'h0000_0000_0000_0002}
    };

    rfi_restore dut (
        .op_is_rfi     (op_is_rfi),
        .cur_msr       (cur_msr),
        .saved_msr     (saved_msr),
        .saved_addr    (saved_addr),
        .new_msr       (new_msr),
        .new_msr_vld   (new_msr_vld),
        .next_addr     (next_addr),
        .next_addr_vld (next_addr_vld)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic bb(input logic [63:0] x, input int k);
        return x[63 - k];
    endfunction

    function automatic logic is_copy(input int k);
        return (k <= 2) || (k >= 4 && k <= 28) || (k == 32) || (k >= 37 && k <= 41) ||
               (k == 49) || (k == 50) || (k >= 52 && k <= 57) || (k >= 60);
    endfunction

    function automatic logic is_keep(input int k);
        return (k == 3) || (k >= 33 && k <= 36) || (k >= 42 && k <= 47);
    endfunction

    function automatic logic [63:0] copy_mask();
        logic [63:0] m = '0;
        for (int k = 0; k < 64; k++) if (is_copy(k)) m[63 - k] = 1'b1;
        return m;
    endfunction

    function automatic logic [63:0] keep_mask();
        logic [63:0] m = '0;
        for (int k = 0; k < 64; k++) if (is_keep(k)) m[63 - k] = 1'b1;
        return m;
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic rfi, input logic [63:0] c, input logic [63:0] s,
                         input logic [63:0] a);
        @(negedge clk);
        op_is_rfi  = rfi;
        cur_msr    = c;
        saved_msr  = s;
        saved_addr = a;
        #1;
    endtask

    task automatic check_all(input logic [63:0] c, input logic [63:0] s,
                             input logic [63:0] a);
        logic [2:0] tc, ts, ta, te, pa, pe;
        logic [63:0] cm, km;
        cm = copy_mask();
        km = keep_mask();
        // R1 direct copies
        chk("R1", new_msr & cm, s & cm);
        // R2 gated machine-check enable
        chk("R2", {63'd0, bb(new_msr, 51)}, {63'd0, bb(c, 3) ? bb(s, 51) : bb(c, 51)});
        // R3 protected field
        tc = {bb(c, 29), bb(c, 30), bb(c, 31)};
        ts = {bb(s, 29), bb(s, 30), bb(s, 31)};
        ta = {bb(new_msr, 29), bb(new_msr, 30), bb(new_msr, 31)};
        te = (tc == 3'b010 && ts == 3'b000) ? tc : ts;
        chk("R3", {61'd0, ta}, {61'd0, te});
        // R4 problem-state override
        pa = {bb(new_msr, 48), bb(new_msr, 58), bb(new_msr, 59)};
        pe = {bb(s, 48) | bb(s, 49), bb(s, 58) | bb(s, 49), bb(s, 59) | bb(s, 49)};
        chk("R4", {61'd0, pa}, {61'd0, pe});
        // R5 untouched bits
        chk("R5", new_msr & km, c & km);
        // R6 aligned address
        chk("R6", next_addr, {a[63:2], 2'b00});
        // R7 both flags raised
        chk("R7", {62'd0, new_msr_vld, next_addr_vld}, 64'd3);
    endtask

    initial begin
        op_is_rfi  = 1'b0;
        cur_msr    = '0;
        saved_msr  = '0;
        saved_addr = '0;
        #1;
        // R8 idle state: flags low
        chk("R8", {62'd0, new_msr_vld, next_addr_vld}, 64'd0);

        for (int v = 0; v < NVEC; v++) begin
            apply(1'b1, VEC[v][191:128], VEC[v][127:64], VEC[v][63:0]);
            check_all(VEC[v][191:128], VEC[v][127:64], VEC[v][63:0]);
        end

        // R8 non-return operation with busy inputs
        apply(1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_4000, 64'h3);
        chk("R8", {62'd0, new_msr_vld, next_addr_vld}, 64'd0);

        // R3 near miss: current 0b010, saved 0b001 -> saved taken
        apply(1'b1, 64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h0);
        check_all(64'h0000_0002_0000_0000, 64'h0000_0001_0000_0000, 64'h0);

        // R2 hypervisor clear, saved enable set -> current kept
        apply(1'b1, 64'h0000_0000_0000_0000, 64'h0000_0000_0000_1000, 64'h1);
        check_all(64'h0000_0000_0000_0000, 64'h0000_0000_0000_1000, 64'h1);

        // R7 flags return after idle
        apply(1'b1, 64'h0, 64'h0, 64'h0);
        chk("R7", {62'd0, new_msr_vld, next_addr_vld}, 64'd3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (10000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule